// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level tree of translation tables that sits in memory. An internal root register holds the frame number of the top-level table, so switching address spaces means loading that one register. For each request the walker fetches a top-level entry and, unless that entry maps a 4 MB page directly, then fetches a second-level entry. Both fetches go through a read port that allows only one read in flight. The walker then checks the access type and privilege against the permission bits.

A walk ends in one of three ways: a translation with its effective attributes, a not-present fault, or a protection fault. When the access is allowed and the final entry still lacks its accessed bit (or its dirty bit, for a write), the walker writes that entry back with the bits set before it signals completion. A requester sends one access at a time. It waits for the one-cycle completion pulse and reads the held results.

Every entry is 32 bits wide:
- bit 0: present
- bit 1: writable
- bit 2: user
- bit 3: write-through
- bit 4: cache-disable
- bit 5: accessed
- bit 6: dirty
- bit 7: large page (top level only)
- bits 11..8: ignored
- bits 31..12: frame number

The virtual address splits as bits 31..22 (top index), bits 21..12 (second index) and bits 11..0 (page offset).

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to address {root, va[31:22], 2'b00}. When a second read is needed, it goes to {top_entry[31:12], va[21:12], 2'b00}. No other reads are issued.
- R2: For a 4 KB mapping, res_paddr is {leaf[31:12], va[11:0]}. res_flags is {leaf bit4, leaf bit3, top bit2 AND leaf bit2, top bit1 AND leaf bit1}, and res_large is 0.
- R3: A present top-level entry with bit 7 set ends the walk after one read. It gives res_paddr = {top[31:22], va[21:0]}, res_large = 1, and res_flags = {top bit4, top bit3, top bit2, top bit1}.
- R4: An entry with bit 0 clear at either level sets res_fault_np and clears res_fault_prot, res_paddr, res_flags and res_large. No write is issued.
- R5: A write access (req_write = 1) whose effective writable bit is 0 sets res_fault_prot, clears res_fault_np and the result fields, and issues no write. A read access ignores the writable bit.
- R6: A user access (req_user = 1) whose effective user bit is 0 gives the same protection fault as R5. A supervisor access ignores the user bit.
- R7: On an allowed access, the walker issues exactly one write when the final entry has bit 5 clear, or when the access is a write and bit 6 is clear. The write goes to that entry's address, with data equal to the entry plus bit 5 set, and bit 6 also set for writes. Otherwise no write is issued.
- R8: Read and write requests are never high together. Each request stays high, with its address (and write data) stable, until the matching read valid or write acknowledge.
- R9: A request is taken only while busy is low. A req_valid seen while busy is high has no effect.
- R10: done is high for exactly one cycle per walk, with busy low. The results stay unchanged from that pulse until the next walk produces a result.
- R11: root_load replaces the root frame in any cycle. A walk already accepted keeps the root value it was accepted with.
- R12: After reset, busy, done, mem_rd_req and mem_wr_req are 0, and the root frame is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_load | input | 1 | Load root frame register |
| root_frame_in | input | 20 | New root frame number |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| busy | output | 1 | Walk in progress; requests refused |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_valid | input | 1 | Read data valid, completes the read |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | 32 | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | One-cycle completion pulse |
| res_paddr | output | 32 | Physical address (0 on fault) |
| res_flags | output | 4 | {cache-disable, write-through, user, writable} |
| res_large | output | 1 | Translation came from a 4 MB page |
| res_fault_np | output | 1 | Not-present fault |
| res_fault_prot | output | 1 | Protection fault |

## Verification
The bench targets these corner cases:
- A protection check that looks only at the second-level entry would let a write through a read-only top-level entry.
- A walker that skips the large-page shortcut would issue a second read and build the wrong offset.
- Write-back logic that writes unconditionally, or forgets the dirty bit on writes, shows up as a wrong write count or wrong write data.
- Requests arriving during a walk, and root reloads in the middle of a walk, are aimed at a design that restarts or that samples the root too late; either would show up as extra reads or reads at the wrong address.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int VA_W = 2*IDX_W + OFF_W,
  localparam int FRM_W = VA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             root_load,
  input  logic [FRM_W-1:0] root_frame_in,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             busy,
  output logic             mem_rd_req,
  output logic [VA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [VA_W-1:0]  mem_rd_data,
  output logic             mem_wr_req,
  output logic [VA_W-1:0]  mem_wr_addr,
  output logic [VA_W-1:0]  mem_wr_data,
  input  logic             mem_wr_ack,
  output logic             done,
  output logic [VA_W-1:0]  res_paddr,
  output logic [3:0]       res_flags,
  output logic             res_large,
  output logic             res_fault_np,
  output logic             res_fault_prot
);
  localparam int LG_W = IDX_W + OFF_W;
  localparam int B_P = 0, B_W = 1, B_U = 2, B_WT = 3, B_CD = 4, B_A = 5, B_D = 6, B_L = 7;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_PTE, S_UPD} st_t;
  st_t st;

  logic [FRM_W-1:0] root_q;
  logic [LG_W-1:0]  va_q;
  logic [VA_W-1:0]  ent_addr_q, wr_data_q;
  logic             wr_q, usr_q, dir_w, dir_u, done_q;

  logic [VA_W-1:0]  ent, upd_val, leaf_pa, next_tab;
  logic             at_pte, leaf, eff_w, eff_u, viol, need_upd;

  always_comb begin
    ent      = mem_rd_data;
    at_pte   = (st == S_PTE);
    leaf     = at_pte | ent[B_L];
    eff_w    = ent[B_W] & (at_pte ? dir_w : 1'b1);
    eff_u    = ent[B_U] & (at_pte ? dir_u : 1'b1);
    viol     = (wr_q & ~eff_w) | (usr_q & ~eff_u);
    need_upd = ~ent[B_A] | (wr_q & ~ent[B_D]);
    upd_val  = ent;
    upd_val[B_A] = 1'b1;
    if (wr_q) upd_val[B_D] = 1'b1;
    leaf_pa  = at_pte ? {ent[VA_W-1:OFF_W], va_q[OFF_W-1:0]}
                      : {ent[VA_W-1:LG_W], va_q[LG_W-1:0]};
    next_tab = {ent[VA_W-1:OFF_W], va_q[LG_W-1:OFF_W], 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      root_q <= '0;
      va_q <= '0;
      ent_addr_q <= '0;
      wr_data_q <= '0;
      wr_q <= 1'b0;
      usr_q <= 1'b0;
      dir_w <= 1'b0;
      dir_u <= 1'b0;
      done_q <= 1'b0;
      res_paddr <= '0;
      res_flags <= '0;
      res_large <= 1'b0;
      res_fault_np <= 1'b0;
      res_fault_prot <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (root_load) root_q <= root_frame_in;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q       <= req_vaddr[LG_W-1:0];
          wr_q       <= req_write;
          usr_q      <= req_user;
          ent_addr_q <= {root_q, req_vaddr[VA_W-1 -: IDX_W], 2'b00};
          st         <= S_DIR;
        end
        S_DIR, S_PTE: if (mem_rd_valid) begin
          if (!ent[B_P] || (leaf && viol)) begin
            st             <= S_IDLE;
            done_q         <= 1'b1;
            res_fault_np   <= ~ent[B_P];
            res_fault_prot <= ent[B_P];
            res_paddr      <= '0;
            res_flags      <= '0;
            res_large      <= 1'b0;
          end else if (!leaf) begin
            dir_w      <= ent[B_W];
            dir_u      <= ent[B_U];
            ent_addr_q <= next_tab;
            st         <= S_PTE;
          end else begin
            res_fault_np   <= 1'b0;
            res_fault_prot <= 1'b0;
            res_paddr      <= leaf_pa;
            res_flags      <= {ent[B_CD], ent[B_WT], eff_u, eff_w};
            res_large      <= ~at_pte;
            if (need_upd) begin
              wr_data_q <= upd_val;
              st        <= S_UPD;
            end else begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        S_UPD: if (mem_wr_ack) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign done        = done_q;
  assign mem_rd_req  = (st == S_DIR) || (st == S_PTE);
  assign mem_rd_addr = ent_addr_q;
  assign mem_wr_req  = (st == S_UPD);
  assign mem_wr_addr = ent_addr_q;
  assign mem_wr_data = wr_data_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         req_valid,
  input logic         mem_rd_req,
  input logic [W-1:0] mem_rd_addr,
  input logic         mem_rd_valid,
  input logic         mem_wr_req,
  input logic [W-1:0] mem_wr_addr,
  input logic [W-1:0] mem_wr_data,
  input logic         mem_wr_ack,
  input logic         done,
  input logic [W-1:0] res_paddr,
  input logic         res_fault_np,
  input logic         res_fault_prot
);
  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_req, mem_wr_req}));
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (done || $stable(res_paddr)));
  // R4
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(res_fault_np && res_fault_prot));
  // R5
  fault_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (res_fault_np || res_fault_prot)) |-> (res_paddr == '0));
  // R7
  wr_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> (mem_wr_data[5] && mem_wr_data[0]));
  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
endmodule

bind pt_walker pt_walker_chk #(.W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req_valid(req_valid),
  .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
  .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .mem_wr_ack(mem_wr_ack), .done(done), .res_paddr(res_paddr),
  .res_fault_np(res_fault_np), .res_fault_prot(res_fault_prot)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic clk = 0, rst_n = 0;
  logic root_load = 0;
  logic [19:0] root_frame_in = '0;
  logic req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] req_vaddr = '0;
  logic busy, mem_rd_req, mem_wr_req, done, res_large, res_fault_np, res_fault_prot;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data, res_paddr;
  logic mem_rd_valid = 0, mem_wr_ack = 0;
  logic [31:0] mem_rd_data = '0;
  logic [3:0] res_flags;

  always #4 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .root_load(root_load), .root_frame_in(root_frame_in),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .busy(busy), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack), .done(done), .res_paddr(res_paddr), .res_flags(res_flags),
    .res_large(res_large), .res_fault_np(res_fault_np), .res_fault_prot(res_fault_prot)
  );

  int n_cmp = 0, n_bad = 0;
  logic [31:0] mem [logic [31:0]];
  logic [19:0] root = '0;
  int rd_cnt = 0, wr_cnt = 0, both_cnt = 0, cycles = 0;
  logic [31:0] rd_log [4];
  logic [31:0] wr_a_log = '0, wr_d_log = '0;
  int rd_lat = 0, wr_lat = 0;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_req && mem_wr_req) both_cnt++;
      if (mem_rd_valid) begin
        mem_rd_valid = 0;
        rd_lat = $urandom % 3;
      end else if (mem_rd_req) begin
        if (rd_lat == 0) begin
          mem_rd_valid = 1;
          mem_rd_data = rdm(mem_rd_addr);
          if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
          rd_cnt++;
        end else rd_lat--;
      end
      if (mem_wr_ack) begin
        mem_wr_ack = 0;
        wr_lat = $urandom % 3;
      end else if (mem_wr_req) begin
        if (wr_lat == 0) begin
          mem_wr_ack = 1;
          mem[mem_wr_addr] = mem_wr_data;
          wr_a_log = mem_wr_addr;
          wr_d_log = mem_wr_data;
          wr_cnt++;
        end else wr_lat--;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL R10 watchdog act=%h exp=%h", cycles, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic model(input logic [31:0] va, input bit w, input bit u, input logic [19:0] rt,
                       output bit np, output bit prot, output logic [31:0] pa, output logic [3:0] fl,
                       output bit lg, output int nrd, output logic [31:0] a0, output logic [31:0] a1,
                       output bit wr, output logic [31:0] wa, output logic [31:0] wd);
    logic [31:0] d, p, e, ea;
    bit ew, eu;
    np = 0; prot = 0; pa = 0; fl = 0; lg = 0; wr = 0; wa = 0; wd = 0; a1 = 0;
    e = 0; ea = 0; ew = 0; eu = 0;
    a0 = {rt, va[31:22], 2'b00};
    d = rdm(a0);
    nrd = 1;
    if (!d[0]) np = 1;
    else if (d[7]) begin
      e = d; ea = a0; ew = d[1]; eu = d[2]; lg = 1; pa = {d[31:22], va[21:0]};
    end else begin
      a1 = {d[31:12], va[21:12], 2'b00};
      nrd = 2;
      p = rdm(a1);
      if (!p[0]) np = 1;
      else begin
        e = p; ea = a1; ew = d[1] & p[1]; eu = d[2] & p[2]; pa = {p[31:12], va[11:0]};
      end
    end
    if (!np) begin
      if ((w && !ew) || (u && !eu)) begin
        prot = 1; pa = 0; lg = 0;
      end else begin
        fl = {e[4], e[3], eu, ew};
        wr = !e[5] || (w && !e[6]);
        wa = ea;
        wd = e | 32'h20 | (w ? 32'h40 : 32'h0);
      end
    end
  endtask

  // poke: 0 none, 1 extra request while busy (R9), 2 root load while busy (R11)
  task automatic walk(input logic [31:0] va, input bit w, input bit u, input int poke,
                      input logic [19:0] new_root);
    bit np, prot, lg, wr, seen;
    logic [31:0] pa, a0, a1, wa, wd;
    logic [3:0] fl;
    int nrd, t;
    model(va, w, u, root, np, prot, pa, fl, lg, nrd, a0, a1, wr, wa, wd);
    @(negedge clk);
    while (busy) @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    req_valid = 1; req_vaddr = va; req_write = w; req_user = u;
    @(negedge clk);
    req_valid = 0;
    if (poke == 1) begin
      req_valid = 1; req_vaddr = ~va; req_write = 0; req_user = 0;
    end else if (poke == 2) begin
      root_load = 1; root_frame_in = new_root;
    end
    seen = 0; t = 0;
    while (!seen && t < 100) begin
      @(negedge clk);
      req_valid = 0; root_load = 0;
      if (done) seen = 1;
      t++;
    end
    chk(seen, "R10 done", {31'b0, seen}, 32'h1);
    if (poke == 2) root = new_root;
    if (seen) begin
      chk(res_fault_np == np, "R4 not-present", {31'b0, res_fault_np}, {31'b0, np});
      chk(res_fault_prot == prot, "R5 R6 protection", {31'b0, res_fault_prot}, {31'b0, prot});
      chk(res_paddr == pa, "R2 R3 paddr", res_paddr, pa);
      chk(res_flags == fl, "R2 R3 flags", {28'b0, res_flags}, {28'b0, fl});
      chk(res_large == lg, "R3 large", {31'b0, res_large}, {31'b0, lg});
      chk(rd_cnt == nrd, "R1 read count", rd_cnt, nrd);
      chk(rd_log[0] == a0, "R1 top address", rd_log[0], a0);
      if (nrd == 2) chk(rd_log[1] == a1, "R1 second address", rd_log[1], a1);
      chk(wr_cnt == (wr ? 1 : 0), "R7 write count", wr_cnt, wr ? 1 : 0);
      if (wr) begin
        chk(wr_a_log == wa, "R7 write address", wr_a_log, wa);
        chk(wr_d_log == wd, "R7 write data", wr_d_log, wd);
      end
      @(negedge clk);
      chk(!done, "R10 pulse width", {31'b0, done}, 32'h0);
      if (poke == 1) begin
        repeat (3) @(negedge clk);
        chk(!busy, "R9 ignored request", {31'b0, busy}, 32'h0);
        chk(rd_cnt == nrd, "R9 no extra reads", rd_cnt, nrd);
      end
    end
  endtask

  function automatic logic [31:0] dir_a(input logic [31:0] va);
    return {root, va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] pte_a(input logic [19:0] tf, input logic [31:0] va);
    return {tf, va[21:12], 2'b00};
  endfunction

  task automatic load_root(input logic [19:0] f);
    @(negedge clk);
    root_load = 1; root_frame_in = f;
    @(negedge clk);
    root_load = 0;
    root = f;
  endtask

  initial begin
    logic [31:0] va;
    logic [19:0] tf;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(!busy, "R12 busy", {31'b0, busy}, 0);
    chk(!done, "R12 done", {31'b0, done}, 0);
    chk(!mem_rd_req && !mem_wr_req, "R12 mem idle", {30'b0, mem_rd_req, mem_wr_req}, 0);

    // R12 root starts at 0; R2 plain 4K read with accessed clear
    va = 32'h0040_3ABC;
    mem[dir_a(va)] = {20'h00050, 12'h007};
    mem[pte_a(20'h00050, va)] = {20'h12345, 12'h01F};
    walk(va, 0, 1, 0, 0);

    load_root(20'h00100);
    // R3 large page, write with A clear
    va = 32'hC123_4567;
    mem[dir_a(va)] = {10'h2AB, 10'h0, 12'h083};
    walk(va, 1, 0, 0, 0);
    // R4 not present at top
    va = 32'h0800_1000;
    mem[dir_a(va)] = 32'h0005_0006;
    walk(va, 0, 0, 0, 0);
    // R4 not present at second level
    va = 32'h0C00_2000;
    mem[dir_a(va)] = {20'h00060, 12'h007};
    mem[pte_a(20'h00060, va)] = 32'hFFFF_F0FE;
    walk(va, 1, 1, 0, 0);
    // R5 write to read-only leaf
    va = 32'h1000_3000;
    mem[dir_a(va)] = {20'h00070, 12'h007};
    mem[pte_a(20'h00070, va)] = {20'h00AAA, 12'h065};
    walk(va, 1, 0, 0, 0);
    // R5 read-only top, writable leaf
    va = 32'h1400_4000;
    mem[dir_a(va)] = {20'h00071, 12'h005};
    mem[pte_a(20'h00071, va)] = {20'h00BBB, 12'h067};
    walk(va, 1, 0, 0, 0);
    // R5 read of read-only is fine
    walk(va, 0, 0, 0, 0);
    // R6 user access to supervisor leaf, then supervisor access is fine
    va = 32'h1800_5000;
    mem[dir_a(va)] = {20'h00072, 12'h007};
    mem[pte_a(20'h00072, va)] = {20'h00CCC, 12'h063};
    walk(va, 0, 1, 0, 0);
    walk(va, 0, 0, 0, 0);
    // R7 A and D already set, write -> no writeback; then A set D clear read
    va = 32'h1C00_6000;
    mem[dir_a(va)] = {20'h00073, 12'h007};
    mem[pte_a(20'h00073, va)] = {20'h00DDD, 12'h07F};
    walk(va, 1, 0, 0, 0);
    mem[pte_a(20'h00073, va)] = {20'h00DDD, 12'h027};
    walk(va, 0, 0, 0, 0);
    walk(va, 1, 0, 0, 0);
    // R9 request during busy
    walk(va, 0, 0, 1, 0);
    // R11 root reload during a walk keeps old root, next walk uses new
    va = 32'h2000_7000;
    mem[dir_a(va)] = {20'h00074, 12'h007};
    mem[pte_a(20'h00074, va)] = {20'h00E0E, 12'h027};
    mem[{20'h00300, va[31:22], 2'b00}] = {10'h155, 10'h0, 12'h0A7};
    walk(va, 0, 0, 2, 20'h00300);
    walk(va, 0, 0, 0, 0);

    // random walks
    for (int i = 0; i < 400; i++) begin
      bit w, u;
      logic [31:0] de, pe;
      va = $urandom;
      w = $urandom % 2;
      u = $urandom % 2;
      tf = $urandom;
      de = {tf, 4'($urandom), 8'($urandom)};
      de[0] = ($urandom % 8) != 0;
      de[7] = ($urandom % 4) == 0;
      pe = $urandom;
      pe[0] = ($urandom % 8) != 0;
      mem[dir_a(va)] = de;
      mem[pte_a(tf, va)] = pe;
      walk(va, w, u, (i % 50 == 7) ? 1 : 0, 0);
    end

    chk(both_cnt == 0, "R8 exclusive requests", both_cnt, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule